// File: doc/BRIEF.md
# Reduced-Pin Gigabit Receive Deserializer

This block sits directly behind the receive pins of a reduced-pin Ethernet PHY link. The PHY drives a continuous receive clock, a four-bit data bus that carries a different nibble on each clock edge, and a single control line that also changes meaning between the two edges. The block captures both halves of every clock period and merges the two nibbles into one byte. It splits the control line into a data-valid flag and a receive-error flag. All results are presented in the receive clock domain, once per cycle.

Half-duplex operation needs a carrier-sense indication, and this interface has no pin for it. The block derives one. Carrier is reported whenever data-valid is set. It is also reported when data-valid is clear, the error flag is set and the assembled byte is all ones at the same time. The receive clock runs at 2.5, 25 or 125 MHz depending on line rate. The logic does not depend on which rate is in use.

Top module: `rgmii_rx_deser`

## Requirements
- R1: While `rxRst` is high at a rising edge of `rxClk`, all outputs (`rxByte`, `rxValid`, `rxErr`, `rxCrs`) are zero after that edge.
- R2: The nibble on `rxd` at a rising edge becomes `rxByte[3:0]`, and the nibble at the following falling edge becomes `rxByte[7:4]`.
- R3: Bit order is preserved: `rxd[0]` maps to `rxByte[0]` on the rising half and to `rxByte[4]` on the falling half, and likewise for the other bits.
- R4: `rxValid` equals the value of `rxCtl` sampled at the rising edge.
- R5: `rxErr` equals the rising-edge `rxCtl` value XOR the falling-edge `rxCtl` value.
- R6: `rxCrs` is high whenever `rxValid` is high.
- R7: `rxCrs` is high when `rxValid` is low, `rxErr` is high and `rxByte` equals 8'hFF.
- R8: In every other case `rxCrs` is low. This includes an error with a byte other than 8'hFF, and an all-ones byte with no error.
- R9: Byte, valid, error and carrier outputs for the period that starts at rising edge k all update together at rising edge k+1, and hold steady until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rxClk | input | 1 | Receive clock from the PHY; both edges carry data |
| rxRst | input | 1 | Synchronous active-high reset |
| rxd | input | 4 | Double-rate receive nibble bus, bit 0 least significant |
| rxCtl | input | 1 | Multiplexed control line (valid on rise, valid XOR error on fall) |
| rxByte | output | 8 | Assembled receive byte |
| rxValid | output | 1 | Data-valid flag |
| rxErr | output | 1 | Receive-error flag |
| rxCrs | output | 1 | Derived carrier-sense flag |

## Verification
Single set bits on each edge (0x01, 0x10, 0x08, 0x80) separate a swapped nibble order from a reversed bit order. Each valid and error combination is driven: valid alone, valid with error, and error alone. Error alone is tried with the byte 0xFF and with nearby values such as 0xFE and 0x7F, and an all-ones byte is also sent with no error at all. Together these single out the false-carrier term and rule out a loose compare on the byte. A back-to-back run of changing bytes, with resets in the middle, exposes any pairing of a nibble with the wrong period and any reset that fails to clear a flag.

// File: rtl/rgmii_rx_pkg.sv
package rgmii_rx_pkg;
  parameter int NIBBLE_W = 4;
  localparam int BYTE_W = 2 * NIBBLE_W;

  typedef struct packed {
    logic clear;
    logic load;
  } dpStrobe_t;
endpackage

// File: rtl/rgmii_rx_datapath.sv
module rgmii_rx_datapath
  import rgmii_rx_pkg::*;
#(
  parameter int NW = NIBBLE_W,
  localparam int BW = 2 * NW
) (
  input  logic          rxClk,
  input  dpStrobe_t     strb,
  input  logic [NW-1:0] rxd,
  output logic          allOnesNext,
  output logic [BW-1:0] rxByte
);
  logic [NW-1:0] loQ;
  logic [NW-1:0] hiQ;
  logic [BW-1:0] byteNext;

  for (genvar b = 0; b < NW; b++) begin : g_lane
    always_ff @(posedge rxClk) begin
      if (strb.clear) loQ[b] <= 1'b0;
      else            loQ[b] <= rxd[b];
    end
    always_ff @(negedge rxClk) begin
      if (strb.clear) hiQ[b] <= 1'b0;
      else            hiQ[b] <= rxd[b];
    end
    assign byteNext[b]      = loQ[b];
    assign byteNext[b + NW] = hiQ[b];
  end

  assign allOnesNext = &byteNext;

  always_ff @(posedge rxClk) begin
    if (strb.clear)     rxByte <= '0;
    else if (strb.load) rxByte <= byteNext;
  end

  // R2: upper half of the byte comes from the falling-edge capture
  a_r2_high_from_fall: assert property (@(posedge rxClk) disable iff (strb.clear)
    strb.load |=> rxByte[BW-1:NW] == $past(hiQ));
  // R2: lower half from the rising-edge capture
  a_r2_low_from_rise: assert property (@(posedge rxClk) disable iff (strb.clear)
    strb.load |=> rxByte[NW-1:0] == $past(loQ));
endmodule

// File: rtl/rgmii_rx_control.sv
module rgmii_rx_control
  import rgmii_rx_pkg::*;
(
  input  logic      rxClk,
  input  logic      rxRst,
  input  logic      rxCtl,
  input  logic      allOnesNext,
  output dpStrobe_t strb,
  output logic      rxValid,
  output logic      rxErr,
  output logic      rxCrs
);
  logic ctlRiseQ;
  logic ctlFallQ;
  logic errNext;
  logic crsNext;

  assign strb.clear = rxRst;
  assign strb.load  = ~rxRst;

  always_ff @(posedge rxClk) begin
    if (rxRst) ctlRiseQ <= 1'b0;
    else       ctlRiseQ <= rxCtl;
  end

  always_ff @(negedge rxClk) begin
    if (rxRst) ctlFallQ <= 1'b0;
    else       ctlFallQ <= rxCtl;
  end

  always_comb begin
    errNext = ctlRiseQ ^ ctlFallQ;
    crsNext = ctlRiseQ | (~ctlRiseQ & errNext & allOnesNext);
  end

  always_ff @(posedge rxClk) begin
    if (rxRst) begin
      rxValid <= 1'b0;
      rxErr   <= 1'b0;
      rxCrs   <= 1'b0;
    end else begin
      rxValid <= ctlRiseQ;
      rxErr   <= errNext;
      rxCrs   <= crsNext;
    end
  end

  // R4: valid follows the rising-edge control sample one cycle later
  a_r4_valid_from_rise: assert property (@(posedge rxClk) disable iff (rxRst)
    strb.load |=> rxValid == $past(ctlRiseQ));
  // R5: error is set when the two control halves disagree
  a_r5_err_from_mismatch: assert property (@(posedge rxClk) disable iff (rxRst)
    strb.load |=> rxErr == ($past(ctlRiseQ) != $past(ctlFallQ)));
  // R6: valid always implies carrier
  a_r6_valid_gives_crs: assert property (@(posedge rxClk) disable iff (rxRst)
    rxValid |-> rxCrs);
  // R8: carrier without valid needs an error
  a_r8_crs_needs_cause: assert property (@(posedge rxClk) disable iff (rxRst)
    (rxCrs && !rxValid) |-> rxErr);
endmodule

// File: rtl/rgmii_rx_deser.sv
module rgmii_rx_deser
  import rgmii_rx_pkg::*;
(
  input  logic                rxClk,
  input  logic                rxRst,
  input  logic [NIBBLE_W-1:0] rxd,
  input  logic                rxCtl,
  output logic [BYTE_W-1:0]   rxByte,
  output logic                rxValid,
  output logic                rxErr,
  output logic                rxCrs
);
  dpStrobe_t strb;
  logic      allOnesNext;

  rgmii_rx_control u_ctrl (
    .rxClk      (rxClk),
    .rxRst      (rxRst),
    .rxCtl      (rxCtl),
    .allOnesNext(allOnesNext),
    .strb       (strb),
    .rxValid    (rxValid),
    .rxErr      (rxErr),
    .rxCrs      (rxCrs)
  );

  rgmii_rx_datapath #(.NW(NIBBLE_W)) u_dp (
    .rxClk      (rxClk),
    .strb       (strb),
    .rxd        (rxd),
    .allOnesNext(allOnesNext),
    .rxByte     (rxByte)
  );

  // R1: reset leaves every output at zero
  a_r1_reset_clears: assert property (@(posedge rxClk)
    rxRst |=> (rxByte == '0 && !rxValid && !rxErr && !rxCrs));
  // R7: carrier from an error alone requires an all-ones byte
  a_r7_false_carrier_byte: assert property (@(posedge rxClk) disable iff (rxRst)
    (rxCrs && !rxValid) |-> (&rxByte));
endmodule

// File: tb/rgmii_rx_deser_test.sv
module rgmii_rx_deser_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] rxd = '0;
  logic       ctl = 1'b0;
  logic [7:0] rxByte;
  logic       rxValid, rxErr, rxCrs;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  typedef struct {
    int b;
    bit v;
    bit e;
    bit c;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  rgmii_rx_deser uut (
    .rxClk(clk), .rxRst(rst), .rxd(rxd), .rxCtl(ctl),
    .rxByte(rxByte), .rxValid(rxValid), .rxErr(rxErr), .rxCrs(rxCrs)
  );

  task automatic cmp(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkOut(input exp_t e, input string tag);
    cmp({tag, " R2 R3 byte"}, rxByte, e.b);
    cmp({tag, " R4 valid"}, rxValid, e.v);
    cmp({tag, " R5 err"}, rxErr, e.e);
    cmp({tag, " R6 R7 R8 crs"}, rxCrs, e.c);
  endtask

  // Drives one byte period; called at negedge+1, returns at negedge+1.
  // R9: the byte pushed here is expected one rising edge later.
  task automatic sendByte(input int b, input bit dv, input bit er);
    exp_t e;
    e.b = b & 8'hFF;
    e.v = dv;
    e.e = er;
    e.c = dv || (!dv && er && e.b == 8'hFF);
    rxd = b[3:0];
    ctl = dv;
    q.push_back(e);
    @(posedge clk); #1;
    checkOut(q.pop_front(), "R9");
    rxd = b[7:4];
    ctl = dv ^ er;
    @(negedge clk); #1;
  endtask

  task automatic doReset();
    exp_t z;
    z.b = 0; z.v = 0; z.e = 0; z.c = 0;
    rst = 1'b1;
    rxd = 4'hF;
    ctl = 1'b1;
    @(posedge clk); #1;
    checkOut(z, "R1");
    @(negedge clk); #1;
    rst = 1'b0;
    q.delete();
    q.push_back(z);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    exp_t z;
    int seed;
    z.b = 0; z.v = 0; z.e = 0; z.c = 0;
    seed = 7;
    repeat (3) @(posedge clk);
    #1 checkOut(z, "R1");
    @(negedge clk); #1;
    rst = 1'b0;
    q.push_back(z);

    // idle
    sendByte(8'h00, 0, 0);
    // bit ordering: R2 R3
    sendByte(8'h01, 1, 0);
    sendByte(8'h10, 1, 0);
    sendByte(8'h08, 1, 0);
    sendByte(8'h80, 1, 0);
    sendByte(8'hA5, 1, 0);
    sendByte(8'h5A, 1, 0);
    // valid with error: R5 R6
    sendByte(8'h3C, 1, 1);
    // false carrier: R7
    sendByte(8'hFF, 0, 1);
    // error without all-ones: R8
    sendByte(8'hFE, 0, 1);
    sendByte(8'h7F, 0, 1);
    // all ones without error: R8
    sendByte(8'hFF, 0, 0);
    sendByte(8'hFF, 1, 0);
    sendByte(8'h0E, 0, 1);

    // mid-stream reset: R1
    doReset();
    sendByte(8'hC3, 1, 0);

    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom(seed + i);
      if (i % 17 == 5) sendByte(8'hFF, 0, 1);
      else sendByte(r & 8'hFF, r[8], r[9] & r[10]);
      if (i == 200) doReset();
    end
    sendByte(8'h00, 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule